// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block is a free-running up-counter that is twice as wide as the data bus. Software reads it one byte at a time through a small register file. The counter is clocked through a divide-by-N prescaler. When it wraps from all ones to zero, it raises an overflow flag. The flag drives an interrupt request whenever the enable bit is set in the control register.

Two read windows look at the same counter. Each window has a high-byte register and a low-byte register. Each window has its own low-byte hold latch, which makes a two-byte read coherent: reading the high byte freezes the matching low byte until the low byte is read.

The primary window is part of the flag-clear handshake. Software reads the status register while the flag is set, and then reads the primary low byte. The alternate window gives software a way to sample the time with no effect on the flag.

Top module: `frt_timer`

## Requirements
- R1: On reset the counter loads RESET_VAL (0xFFFC by default, high byte 0xFF, low byte 0xFC). Control and status read as zero and irq is low.
- R2: The counter increments by one every PRESCALE clock cycles. The first increment happens on the PRESCALE-th rising edge after reset is released.
- R3: The edge on which the count goes from all ones to zero sets the overflow flag. The flag is status bit BUS_W-1, and the other status bits read 0.
- R4: irq is high exactly while the overflow flag is 1 and control bit 0 (interrupt enable) is 1.
- R5: The flag clears only in one case: a primary low-byte read follows a status read that was made while the flag was set. A primary low-byte read without that earlier status read leaves the flag set.
- R6: Register reads never change the counter value.
- R7: Reads of the alternate window never change the flag or irq.
- R8: A low-byte register returns the live low byte until its high byte is read. The high-byte read captures the low byte, and the captured value is returned until that low byte is next read.
- R9: The register map is: address 0 control, 1 status, 2 primary high, 3 primary low, 4 alternate high, 5 alternate low; other addresses read 0. Only control bit 0 is writable. Writes to any other address are ignored.
- R10: Each window has its own latch and armed state. Reading one window does not disturb the latch of the other.
- R11: If an overflow happens in the same cycle as a clearing primary low-byte read, the flag stays set.
- R12: A new overflow cancels a pending status read. A primary low-byte read after that new overflow leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe; side effects take effect at the clock edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, combinational from addr while rd_en is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with BUS_W=4, PRESCALE=2 and RESET_VAL=0xFC. The counter is then only 8 bits wide and wraps every 512 cycles. This lets the bench sweep every count value through the alternate window several times, checking each against an arithmetic model of elapsed cycles. The short wrap period also makes it cheap to place reads exactly on the cycle before a wrap edge. That placement exercises the set-over-clear priority and the cancelling of a pending status read.

// File: rtl/frt_pkg.sv
package frt_pkg;
   typedef logic [2:0] addr_t;
   localparam addr_t A_CTRL = 3'd0;
   localparam addr_t A_STAT = 3'd1;
   localparam addr_t A_PHI  = 3'd2;
   localparam addr_t A_PLO  = 3'd3;
   localparam addr_t A_AHI  = 3'd4;
   localparam addr_t A_ALO  = 3'd5;
   localparam int unsigned N_WIN = 2;
endpackage

// File: rtl/frt_prescale.sv
module frt_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);
   localparam bit IS_POW2 = (DIV & (DIV - 1)) == 0;

   if (DIV < 2) begin : g_bad_div
      $error("frt_prescale: DIV must be at least 2");
   end

   logic [PW-1:0] pre;

   if (IS_POW2) begin : g_pow2
      // free-wrapping counter, terminal count is all ones
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pre <= '0;
         else        pre <= pre + 1'b1;
      end
      assign tick = &pre;
   end else begin : g_mod
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pre <= '0;
         else if (pre == LAST) pre <= '0;
         else                 pre <= pre + 1'b1;
      end
      assign tick = (pre == LAST);
   end

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
   parameter int unsigned CNT_W = 16,
   parameter logic [CNT_W-1:0] RST_V = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= RST_V;
      else if (tick) cnt <= cnt + 1'b1;
   end

   assign wrap = tick & (&cnt);

   // R2
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/frt_window.sv
module frt_window #(
   parameter int unsigned BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] cnt_hi,
   input  logic [BUS_W-1:0] cnt_lo,
   input  logic             hi_rd,
   input  logic             lo_rd,
   output logic [BUS_W-1:0] hi_q,
   output logic [BUS_W-1:0] lo_q
);
   logic             held;
   logic [BUS_W-1:0] lo_latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= 1'b0;
         lo_latch <= '0;
      end else if (hi_rd) begin
         held     <= 1'b1;
         lo_latch <= cnt_lo;
      end else if (lo_rd) begin
         held     <= 1'b0;
      end
   end

   assign hi_q = cnt_hi;
   assign lo_q = held ? lo_latch : cnt_lo;

   // R8
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rd |=> (held && lo_latch == $past(cnt_lo)));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !hi_rd) |=> $stable(lo_latch));
   // R8
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rd && !hi_rd) |=> !held);
endmodule

// File: rtl/frt_ovf.sv
module frt_ovf (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic stat_rd,
   input  logic plo_rd,
   output logic flag
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         flag  <= 1'b0;
      end else begin
         if (set_evt)              armed <= 1'b0;
         else if (plo_rd)          armed <= 1'b0;
         else if (stat_rd && flag) armed <= 1'b1;

         if (set_evt)              flag <= 1'b1;
         else if (plo_rd && armed) flag <= 1'b0;
      end
   end

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag);
   // R12
   rearm_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> !armed);
   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plo_rd && armed && !set_evt) |=> !flag);
   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !plo_rd) |=> flag);
endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
   parameter int unsigned BUS_W     = 8,
   parameter int unsigned PRESCALE  = 4,
   parameter int unsigned RESET_VAL = 'hFFFC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             irq
);
   import frt_pkg::*;

   localparam int unsigned CNT_W = 2 * BUS_W;
   localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_VAL);

   if (BUS_W < 2 || BUS_W > 16) begin : g_bad_bus
      $error("frt_timer: BUS_W out of range");
   end

   logic             tick, wrap, flag, ie;
   logic [CNT_W-1:0] cnt;
   logic [N_WIN-1:0] hi_rd_v, lo_rd_v;
   logic [BUS_W-1:0] win_hi [N_WIN];
   logic [BUS_W-1:0] win_lo [N_WIN];
   logic             unused_wdata;

   assign unused_wdata = ^wdata[BUS_W-1:1];

   frt_prescale #(.DIV(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   frt_counter #(.CNT_W(CNT_W), .RST_V(RST_V)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wrap(wrap));

   // window 0 = primary, window 1 = alternate
   assign hi_rd_v = {rd_en && (addr == A_AHI), rd_en && (addr == A_PHI)};
   assign lo_rd_v = {rd_en && (addr == A_ALO), rd_en && (addr == A_PLO)};

   for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
      frt_window #(.BUS_W(BUS_W)) u_win (
         .clk(clk), .rst_n(rst_n),
         .cnt_hi(cnt[CNT_W-1:BUS_W]), .cnt_lo(cnt[BUS_W-1:0]),
         .hi_rd(hi_rd_v[gi]), .lo_rd(lo_rd_v[gi]),
         .hi_q(win_hi[gi]), .lo_q(win_lo[gi]));
   end

   frt_ovf u_ovf (
      .clk(clk), .rst_n(rst_n), .set_evt(wrap),
      .stat_rd(rd_en && (addr == A_STAT)),
      .plo_rd(lo_rd_v[0]), .flag(flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ie <= 1'b0;
      else if (wr_en && addr == A_CTRL)   ie <= wdata[0];
   end

   assign irq = flag & ie;

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            A_CTRL:  rdata = {{(BUS_W-1){1'b0}}, ie};
            A_STAT:  rdata = {flag, {(BUS_W-1){1'b0}}};
            A_PHI:   rdata = win_hi[0];
            A_PLO:   rdata = win_lo[0];
            A_AHI:   rdata = win_hi[1];
            A_ALO:   rdata = win_lo[1];
            default: rdata = '0;
         endcase
      end
   end

   // R7
   alt_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == A_AHI || addr == A_ALO) && !wrap) |=> $stable(flag));
   // R6
   rd_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !tick) |=> $stable(cnt));
endmodule

// File: tb/frt_timer_bench.sv
module frt_timer_bench;
   import frt_pkg::*;

   localparam int BW  = 4;
   localparam int P   = 2;
   localparam int RV  = 'hFC;
   localparam int MOD = 1 << (2 * BW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr = '0;
   logic [BW-1:0] wdata = '0;
   logic [BW-1:0] rdata;
   logic          irq;

   int n = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   frt_timer #(.BUS_W(BW), .PRESCALE(P), .RESET_VAL(RV)) u_frt_timer (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) n <= n + 1;

   function automatic int exp_cnt(int k);
      return (RV + k / P) % MOD;
   endfunction

   function automatic bit is_pre(int k);
      return ((k + 1) % P == 0) && (exp_cnt(k + 1) == 0);
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic rd(addr_t a, output int d, output int k);
      k = n;
      rd_en = 1'b1; addr = a;
      #1 d = int'(rdata);
      @(posedge clk); #1 rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr(addr_t a, int v);
      wr_en = 1'b1; addr = a; wdata = BW'(v);
      @(posedge clk); #1 wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(int c);
      repeat (c) @(negedge clk);
   endtask

   task automatic wait_pre();
      while (!is_pre(n)) @(negedge clk);
   endtask

   task automatic wait_wrap();
      wait_pre();
      idle(1);
   endtask

   localparam int FBIT = 1 << (BW - 1);
   localparam int LMSK = (1 << BW) - 1;

   initial begin
      int d, k, k2, lat;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      rd(A_PHI, d, k); chk(d == 'hF, "R1 high byte", d, 'hF);
      rd(A_PLO, d, k); chk(d == 'hC, "R1 low byte", d, 'hC);
      rd(A_CTRL, d, k); chk(d == 0, "R1 control", d, 0);
      rd(A_STAT, d, k); chk(d == 0, "R1 status", d, 0);

      // R8 coherent pair and release
      idle(3);
      rd(A_PHI, d, k); lat = exp_cnt(k) & LMSK;
      chk(d == exp_cnt(k) >> BW, "R8 high", d, exp_cnt(k) >> BW);
      idle(5);
      rd(A_PLO, d, k2); chk(d == lat, "R8 latched low", d, lat);
      rd(A_PLO, d, k2); chk(d == (exp_cnt(k2) & LMSK), "R8 live after release", d, exp_cnt(k2) & LMSK);
      idle(1);
      rd(A_PLO, d, k2); chk(d == (exp_cnt(k2) & LMSK), "R8 transparent", d, exp_cnt(k2) & LMSK);

      // R10 independent latches
      rd(A_PHI, d, k); lat = exp_cnt(k) & LMSK;
      idle(2);
      rd(A_AHI, d, k2);
      rd(A_ALO, d, k);  chk(d == (exp_cnt(k2) & LMSK), "R10 alt latch", d, exp_cnt(k2) & LMSK);
      idle(3);
      rd(A_PLO, d, k);  chk(d == lat, "R10 primary latch kept", d, lat);

      // R9 writes ignored, control writable, unmapped reads zero
      wr(A_AHI, 5); wr(A_PLO, 'hA); wr(A_PHI, 3); wr(A_ALO, 9); wr(A_STAT, 'hF);
      rd(A_AHI, d, k); chk(d == exp_cnt(k) >> BW, "R9 count unchanged by writes hi", d, exp_cnt(k) >> BW);
      rd(A_ALO, d, k2); chk(d == (exp_cnt(k) & LMSK), "R9 count unchanged by writes lo", d, exp_cnt(k) & LMSK);
      wr(A_CTRL, 'hF); rd(A_CTRL, d, k); chk(d == 1, "R9 control bit0 only", d, 1);
      wr(A_CTRL, 0);   rd(A_CTRL, d, k); chk(d == 0, "R9 control cleared", d, 0);
      rd(3'd6, d, k); chk(d == 0, "R9 unmapped", d, 0);

      // R2 R6 R7 sweep through the alternate window over several wraps
      for (int i = 0; i < 700; i++) begin
         rd(A_AHI, d, k);
         chk(d == exp_cnt(k) >> BW, "R2 R6 sweep high", d, exp_cnt(k) >> BW);
         rd(A_ALO, d, k2);
         chk(d == (exp_cnt(k) & LMSK), "R2 R6 sweep low", d, exp_cnt(k) & LMSK);
      end
      rd(A_STAT, d, k); chk(d == FBIT, "R3 R7 flag set after alt sweep", d, FBIT);

      // R3 R5 clear right after a wrap
      wait_wrap();
      rd(A_STAT, d, k); chk(d == FBIT, "R3 flag after wrap", d, FBIT);
      rd(A_PLO, d, k);
      rd(A_STAT, d, k); chk(d == 0, "R5 cleared by status then low", d, 0);

      // R4 irq, R5 negative, R7
      wr(A_CTRL, 1);
      chk(irq == 1'b0, "R4 irq low with flag clear", int'(irq), 0);
      wait_wrap();
      chk(irq == 1'b1, "R4 irq high", int'(irq), 1);
      wr(A_CTRL, 0);
      chk(irq == 1'b0, "R4 irq masked", int'(irq), 0);
      wr(A_CTRL, 1);
      chk(irq == 1'b1, "R4 irq unmasked", int'(irq), 1);
      rd(A_PLO, d, k);
      rd(A_STAT, d, k); chk(d == FBIT, "R5 low read alone keeps flag", d, FBIT);
      rd(A_ALO, d, k);
      rd(A_AHI, d, k);
      rd(A_ALO, d, k);
      chk(irq == 1'b1, "R7 alt reads keep irq", int'(irq), 1);
      rd(A_STAT, d, k); chk(d == FBIT, "R7 alt reads keep flag", d, FBIT);
      rd(A_PLO, d, k);
      rd(A_STAT, d, k); chk(d == 0, "R5 cleared", d, 0);
      chk(irq == 1'b0, "R4 irq drops with flag", int'(irq), 0);

      // R12 new overflow cancels a pending status read
      wait_wrap();
      rd(A_STAT, d, k);
      wait_wrap();
      rd(A_PLO, d, k);
      rd(A_STAT, d, k); chk(d == FBIT, "R12 stale arm ignored", d, FBIT);
      rd(A_PLO, d, k);
      rd(A_STAT, d, k); chk(d == 0, "R12 fresh arm clears", d, 0);

      // R11 clearing read lands on the wrap edge
      wait_wrap();
      while (!is_pre(n + 1)) @(negedge clk);
      rd(A_STAT, d, k);
      chk(is_pre(n) == 1'b1, "R11 timing setup", int'(is_pre(n)), 1);
      rd(A_PLO, d, k);
      rd(A_STAT, d, k); chk(d == FBIT, "R11 set wins", d, FBIT);
      chk(irq == 1'b1, "R11 irq held", int'(irq), 1);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule